// File: doc/BRIEF.md
# Switch-Side Access Coalescing Table

The block sits inside a multi-port switch, in front of one target memory. Several GPU ports send it memory requests: plain loads, and reductions that add their data into a memory word. Requests that name the same address are coalesced. A load to an address that has no open session opens one and sends a single read to memory. Later loads to that address queue behind it. When the read data comes back, it goes to every queued requester, one response per cycle, and is then kept in the table. Loads that arrive after that are served from the kept copy. Reductions to one address are summed into an accumulator, and one write carries the total to memory.

A session ends after a fixed number of contributors, given by a configuration input (normally the number of GPUs that take part). The entry is then freed for reuse. The table is fully associative. A request to a new address while every entry is busy is held off with backpressure. So is any request that meets an open session of the other kind (a load against a reduction, or the reverse).

Top module: `req_merge_table`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_valid` and `mem_req_valid` are low. With an empty table, `req_ready` is high.
- R2: A load (`req_op`=0) to an address with no open session is accepted. On the next clock edge it produces exactly one memory read: `mem_req_valid`=1, `mem_req_write`=0, `mem_req_addr` set to the request address, `mem_req_data`=0. Further loads to that address accepted before the data returns produce no memory request and no response.
- R3: A read return is sampled on the edge where `mem_rsp_valid` is high with an address that is waiting. Starting on the second edge after that one, the block sends one response per cycle to each queued requester. The responses follow arrival order and carry the requester's port id, the address and the returned data.
- R4: From the edge that samples a read return until the last queued response has gone out, `req_ready` stays low for every request.
- R5: A load to an address whose data is already held is answered on the next edge with that data and its own port id. It creates no memory request.
- R6: A session closes once it has counted `cfg_contributors` requests and sent all its responses. The next request to that address opens a new session; for a load, that means a new memory read.
- R7: A reduction (`req_op`=1) session starts its accumulator with the first contributor's data and adds each later contributor's data, modulo 2^DATA_W. On the edge after the last contributor is accepted, it issues one write (`mem_req_write`=1) of the sum to the address. A reduction never produces a response.
- R8: With `cfg_contributors`=1, a reduction is written to memory at once. A load gets its own read and its one response, and then leaves no entry behind.
- R9: When all entries hold open sessions, a request to a new address sees `req_ready` low. Requests to addresses already in the table are still accepted, and a closing session frees room for the held request.
- R10: A request whose address matches an open session of the other kind sees `req_ready` low until that session closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_contributors | input | CNT_W | Requests per session (1 to NPORTS) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_port | input | PORT_W | Requesting port id |
| req_op | input | 1 | 0 = load, 1 = reduction |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Reduction operand |
| mem_req_valid | output | 1 | Memory request strobe (always accepted) |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_data | output | DATA_W | Write data (0 on reads) |
| mem_rsp_valid | input | 1 | Read data returning |
| mem_rsp_addr | input | ADDR_W | Address of returned data |
| mem_rsp_data | input | DATA_W | Returned data |
| rsp_valid | output | 1 | Response to a port |
| rsp_port | output | PORT_W | Destination port id |
| rsp_addr | output | ADDR_W | Address answered |
| rsp_data | output | DATA_W | Load data |

## Verification
The bench targets these corner cases:
- A second load to a waiting address. A design that reissues it would show a second read.
- The fan-out order with four queued ports in scrambled order. A design that answers by port number or skips a queue slot would give the wrong sequence.
- A reduction sum that wraps past 2^32, and a single-contributor configuration. A wrong accumulator initialisation or a missed close would surface here.
- A full table, and a load meeting an open reduction. A design that overwrote an entry or merged across kinds would issue a wrong write, or accept when it should stall.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {
    SES_IDLE     = 2'd0,
    SES_LD_WAIT  = 2'd1,
    SES_LD_READY = 2'd2,
    SES_REDUCE   = 2'd3
  } ses_t;

  localparam logic OP_LOAD   = 1'b0;
  localparam logic OP_REDUCE = 1'b1;
endpackage

// File: rtl/mt_match.sv
// Fully associative address lookup over the live entries; lowest index wins.
module mt_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] live,
  input  logic [ADDR_W-1:0]  tag [ENTRIES],
  input  logic [ADDR_W-1:0]  key,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  logic [ENTRIES-1:0] eq;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign eq[g] = live[g] && (tag[g] == key);
    end
  endgenerate

  always_comb begin
    hit     = |eq;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mt_content_ram.sv
// Simple dual-port store for returned load data, synchronous read.
module mt_content_ram #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mt_fanout.sv
// Walks the queued requesters of one filled entry, one per cycle.
module mt_fanout #(
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] filled_mask,
  input  logic [CNT_W-1:0]   cur_count,
  output logic               busy,
  output logic [IDX_W-1:0]   cur_idx,
  output logic [CNT_W-1:0]   ptr,
  output logic               last
);
  logic [IDX_W-1:0] next_idx;

  always_comb begin
    next_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (filled_mask[i]) next_idx = IDX_W'(i);
    end
  end

  assign last = busy && (ptr == cur_count - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cur_idx <= '0;
      ptr     <= '0;
    end else if (!busy) begin
      if (|filled_mask) begin
        busy    <= 1'b1;
        cur_idx <= next_idx;
        ptr     <= '0;
      end
    end else if (last) begin
      busy <= 1'b0;
    end else begin
      ptr <= ptr + CNT_W'(1);
    end
  end
endmodule

// File: rtl/req_merge_table.sv
module req_merge_table
  import mt_pkg::*;
#(
  parameter int NPORTS  = 4,
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  localparam int PORT_W = $clog2(NPORTS),
  localparam int CNT_W  = $clog2(NPORTS + 1),
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_contributors,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PORT_W-1:0] req_port,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_addr,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [PORT_W-1:0] rsp_port,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  // Entry state
  ses_t              state_q  [ENTRIES];
  logic [ADDR_W-1:0] addr_q   [ENTRIES];
  logic [CNT_W-1:0]  cnt_q    [ENTRIES];
  logic [DATA_W-1:0] acc_q    [ENTRIES];
  logic [PORT_W-1:0] wait_q   [ENTRIES][NPORTS];
  logic [ENTRIES-1:0] filled_q;

  logic [ENTRIES-1:0] live, await_data, drain_mask;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      live[i]       = (state_q[i] != SES_IDLE);
      await_data[i] = (state_q[i] == SES_LD_WAIT) && !filled_q[i];
      drain_mask[i] = (state_q[i] == SES_LD_WAIT) && filled_q[i];
    end
  end

  // Free slot search
  logic             has_free;
  logic [IDX_W-1:0] free_idx;
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // Request lookup
  logic             r_hit;
  logic [IDX_W-1:0] r_idx;
  mt_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_req_match (
    .live(live), .tag(addr_q), .key(req_addr), .hit(r_hit), .hit_idx(r_idx)
  );

  // Read-return lookup (only entries still waiting for data)
  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  mt_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_rsp_match (
    .live(await_data), .tag(addr_q), .key(mem_rsp_addr), .hit(m_hit), .hit_idx(m_idx)
  );

  // Fan-out walker
  logic             fan_busy, fan_last;
  logic [IDX_W-1:0] fan_idx;
  logic [CNT_W-1:0] fan_ptr;
  mt_fanout #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_fanout (
    .clk(clk), .rst(rst), .filled_mask(drain_mask), .cur_count(cnt_q[fan_idx]),
    .busy(fan_busy), .cur_idx(fan_idx), .ptr(fan_ptr), .last(fan_last)
  );

  // Cached load data
  mt_content_ram #(.DEPTH(ENTRIES), .WIDTH(DATA_W)) u_content (
    .clk(clk), .we(mem_rsp_valid && m_hit), .waddr(m_idx), .wdata(mem_rsp_data),
    .raddr(fan_busy ? fan_idx : r_idx), .rdata(rsp_data)
  );

  // Acceptance
  logic want_load, hit_is_load, same_kind, fire, closes;
  logic [CNT_W-1:0]  cnt_next;
  logic [DATA_W-1:0] acc_next;

  assign want_load   = (req_op == OP_LOAD);
  assign hit_is_load = (state_q[r_idx] == SES_LD_WAIT) || (state_q[r_idx] == SES_LD_READY);
  assign same_kind   = want_load ? hit_is_load : (state_q[r_idx] == SES_REDUCE);
  assign req_ready   = !(|drain_mask) && (r_hit ? same_kind : has_free);
  assign fire        = req_valid && req_ready;
  assign cnt_next    = cnt_q[r_idx] + CNT_W'(1);
  assign closes      = (cnt_next == cfg_contributors);
  assign acc_next    = acc_q[r_idx] + req_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) state_q[i] <= SES_IDLE;
      filled_q      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_data  <= '0;
      rsp_valid     <= 1'b0;
      rsp_port      <= '0;
      rsp_addr      <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      rsp_valid     <= 1'b0;

      if (mem_rsp_valid && m_hit) filled_q[m_idx] <= 1'b1;

      if (fan_busy) begin
        rsp_valid <= 1'b1;
        rsp_port  <= wait_q[fan_idx][fan_ptr[PORT_W-1:0]];
        rsp_addr  <= addr_q[fan_idx];
        if (fan_last) begin
          filled_q[fan_idx] <= 1'b0;
          state_q[fan_idx]  <= (cnt_q[fan_idx] == cfg_contributors) ? SES_IDLE : SES_LD_READY;
        end
      end

      if (fire) begin
        if (r_hit) begin
          cnt_q[r_idx] <= cnt_next;
          unique case (state_q[r_idx])
            SES_LD_WAIT: wait_q[r_idx][cnt_q[r_idx][PORT_W-1:0]] <= req_port;
            SES_LD_READY: begin
              rsp_valid <= 1'b1;
              rsp_port  <= req_port;
              rsp_addr  <= req_addr;
              if (closes) state_q[r_idx] <= SES_IDLE;
            end
            SES_REDUCE: begin
              acc_q[r_idx] <= acc_next;
              if (closes) begin
                state_q[r_idx] <= SES_IDLE;
                mem_req_valid  <= 1'b1;
                mem_req_write  <= 1'b1;
                mem_req_addr   <= req_addr;
                mem_req_data   <= acc_next;
              end
            end
            default: ;
          endcase
        end else if (want_load) begin
          state_q[free_idx]   <= SES_LD_WAIT;
          addr_q[free_idx]    <= req_addr;
          cnt_q[free_idx]     <= CNT_W'(1);
          wait_q[free_idx][0] <= req_port;
          filled_q[free_idx]  <= 1'b0;
          mem_req_valid       <= 1'b1;
          mem_req_write       <= 1'b0;
          mem_req_addr        <= req_addr;
          mem_req_data        <= '0;
        end else if (cfg_contributors == CNT_W'(1)) begin
          mem_req_valid <= 1'b1;
          mem_req_write <= 1'b1;
          mem_req_addr  <= req_addr;
          mem_req_data  <= req_data;
        end else begin
          state_q[free_idx] <= SES_REDUCE;
          addr_q[free_idx]  <= req_addr;
          cnt_q[free_idx]   <= CNT_W'(1);
          acc_q[free_idx]   <= req_data;
        end
      end
    end
  end
endmodule

// File: rtl/req_merge_table_chk.sv
module req_merge_table_chk
  import mt_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic req_op,
  input logic mem_req_valid,
  input logic mem_req_write,
  input logic rsp_valid
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !mem_req_valid));

  // R2
  read_from_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_write) |-> $past(req_valid && req_ready && (req_op == OP_LOAD)));

  // R7
  write_from_reduce_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> $past(req_valid && req_ready && (req_op == OP_REDUCE)));

  // R2
  miss_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_write) |-> !rsp_valid);
endmodule

bind req_merge_table req_merge_table_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write), .rsp_valid(rsp_valid)
);

// File: tb/req_merge_table_tb.sv
`timescale 1ns/1ps
module req_merge_table_tb;
  import mt_pkg::*;
  localparam int NPORTS = 4, ENTRIES = 4, ADDR_W = 16, DATA_W = 32;
  localparam int PORT_W = $clog2(NPORTS), CNT_W = $clog2(NPORTS + 1);

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic [CNT_W-1:0]  cfg_contributors = CNT_W'(3);
  logic              req_valid = 1'b0, req_ready, req_op = 1'b0;
  logic [PORT_W-1:0] req_port = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic              mem_req_valid, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_data;
  logic              mem_rsp_valid = 1'b0;
  logic [ADDR_W-1:0] mem_rsp_addr = '0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic              rsp_valid;
  logic [PORT_W-1:0] rsp_port;
  logic [ADDR_W-1:0] rsp_addr;
  logic [DATA_W-1:0] rsp_data;

  req_merge_table #(.NPORTS(NPORTS), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_contributors(cfg_contributors),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_addr(mem_rsp_addr), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  int checks = 0, failures = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic send(input int p, input logic op, input int a, input logic [DATA_W-1:0] d);
    req_port = PORT_W'(p); req_op = op; req_addr = ADDR_W'(a); req_data = d; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic probe_stall(input string tag, input logic op, input int a);
    req_op = op; req_addr = ADDR_W'(a); req_valid = 1'b1;
    #1;
    check(tag, {63'd0, req_ready}, 64'd0);
    req_valid = 1'b0;
  endtask

  task automatic mem_return(input int a, input logic [DATA_W-1:0] d);
    mem_rsp_addr = ADDR_W'(a); mem_rsp_data = d; mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input int p, input int a, input logic [DATA_W-1:0] d);
    check(tag, {13'd0, rsp_valid, rsp_port, rsp_addr, rsp_data},
               {13'd0, 1'b1, PORT_W'(p), ADDR_W'(a), d});
  endtask

  task automatic expect_mem(input string tag, input logic wr, input int a, input logic [DATA_W-1:0] d);
    check(tag, {14'd0, mem_req_valid, mem_req_write, mem_req_addr, mem_req_data},
               {14'd0, 1'b1, wr, ADDR_W'(a), d});
  endtask

  task automatic expect_quiet_mem(input string tag);
    check(tag, {63'd0, mem_req_valid}, 64'd0);
  endtask

  task automatic expect_quiet_rsp(input string tag);
    check(tag, {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_reset();
    check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    check("R1 mem_req_valid after reset", {63'd0, mem_req_valid}, 64'd0);
    check("R1 req_ready empty table", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic t_load_merge();
    cfg_contributors = CNT_W'(3);
    send(0, OP_LOAD, 'h10, 0);
    expect_mem("R2 first load reads", 1'b0, 'h10, 0);
    send(2, OP_LOAD, 'h10, 0);
    expect_quiet_mem("R2 merged load no read");
    expect_quiet_rsp("R2 merged load no rsp");
    mem_return('h10, 32'hCAFE0001);
    check("R4 ready low after return", {63'd0, req_ready}, 64'd0);
    expect_quiet_rsp("R3 no rsp on first edge");
    @(negedge clk);
    expect_quiet_rsp("R3 no rsp on first edge after return");
    @(negedge clk);
    expect_rsp("R3 fan-out first", 0, 'h10, 32'hCAFE0001);
    check("R4 ready low during fan-out", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    expect_rsp("R3 fan-out second", 2, 'h10, 32'hCAFE0001);
    @(negedge clk);
    expect_quiet_rsp("R3 fan-out ends");
    check("R4 ready back", {63'd0, req_ready}, 64'd1);
    send(1, OP_LOAD, 'h10, 0);
    expect_rsp("R5 cached hit", 1, 'h10, 32'hCAFE0001);
    expect_quiet_mem("R5 cached hit no memory");
    send(3, OP_LOAD, 'h10, 0);
    expect_mem("R6 new session reads", 1'b0, 'h10, 0);
    mem_return('h10, 32'h00001234);
    @(negedge clk);
    @(negedge clk);
    expect_rsp("R6 new session data", 3, 'h10, 32'h00001234);
    @(negedge clk);
    send(0, OP_LOAD, 'h10, 0);
    expect_rsp("R5 hit new data", 0, 'h10, 32'h00001234);
    send(1, OP_LOAD, 'h10, 0);
    expect_rsp("R5 closing hit", 1, 'h10, 32'h00001234);
  endtask

  task automatic t_reduce();
    cfg_contributors = CNT_W'(3);
    send(0, OP_REDUCE, 'h20, 32'd5);
    expect_quiet_mem("R7 first contributor no write");
    send(1, OP_REDUCE, 'h20, 32'hFFFFFFFF);
    expect_quiet_mem("R7 second contributor no write");
    expect_quiet_rsp("R7 no rsp");
    send(2, OP_REDUCE, 'h20, 32'd7);
    expect_mem("R7 wrapped sum written", 1'b1, 'h20, 32'h0000000B);
    expect_quiet_rsp("R7 no rsp on close");
  endtask

  task automatic t_single();
    cfg_contributors = CNT_W'(1);
    send(3, OP_REDUCE, 'h30, 32'd9);
    expect_mem("R8 single reduce writes", 1'b1, 'h30, 32'd9);
    send(1, OP_LOAD, 'h31, 0);
    expect_mem("R8 single load reads", 1'b0, 'h31, 0);
    mem_return('h31, 32'h0000AA55);
    @(negedge clk);
    @(negedge clk);
    expect_rsp("R8 single load rsp", 1, 'h31, 32'h0000AA55);
    @(negedge clk);
    send(2, OP_LOAD, 'h31, 0);
    expect_mem("R8 entry freed rereads", 1'b0, 'h31, 0);
    mem_return('h31, 32'h1);
    @(negedge clk);
    @(negedge clk);
    expect_rsp("R8 second single rsp", 2, 'h31, 32'h1);
    @(negedge clk);
  endtask

  task automatic t_full();
    cfg_contributors = CNT_W'(2);
    for (int i = 0; i < ENTRIES; i++) send(0, OP_REDUCE, 'h40 + i, i);
    probe_stall("R9 full table stalls new address", OP_REDUCE, 'h44);
    send(1, OP_REDUCE, 'h41, 32'd10);
    expect_mem("R9 hit accepted when full", 1'b1, 'h41, 32'd11);
    send(1, OP_REDUCE, 'h44, 32'd3);
    expect_quiet_mem("R9 freed entry reused");
    send(1, OP_REDUCE, 'h40, 32'd1);
    expect_mem("R9 close 0x40", 1'b1, 'h40, 32'd1);
    send(1, OP_REDUCE, 'h42, 32'd1);
    expect_mem("R9 close 0x42", 1'b1, 'h42, 32'd3);
    send(1, OP_REDUCE, 'h43, 32'd1);
    expect_mem("R9 close 0x43", 1'b1, 'h43, 32'd4);
    send(2, OP_REDUCE, 'h44, 32'd4);
    expect_mem("R9 close 0x44", 1'b1, 'h44, 32'd7);
  endtask

  task automatic t_kind();
    cfg_contributors = CNT_W'(2);
    send(0, OP_REDUCE, 'h50, 32'd1);
    probe_stall("R10 load against reduction stalls", OP_LOAD, 'h50);
    send(1, OP_REDUCE, 'h50, 32'd2);
    expect_mem("R10 reduction closes", 1'b1, 'h50, 32'd3);
    send(2, OP_LOAD, 'h50, 0);
    expect_mem("R10 load after close reads", 1'b0, 'h50, 0);
    probe_stall("R10 reduction against load stalls", OP_REDUCE, 'h50);
    mem_return('h50, 32'h77);
    @(negedge clk);
    @(negedge clk);
    expect_rsp("R10 load rsp", 2, 'h50, 32'h77);
    @(negedge clk);
    send(3, OP_LOAD, 'h50, 0);
    expect_rsp("R10 closing hit", 3, 'h50, 32'h77);
  endtask

  task automatic t_order();
    int order [4] = '{3, 1, 0, 2};
    cfg_contributors = CNT_W'(4);
    send(order[0], OP_LOAD, 'h60, 0);
    expect_mem("R2 order first read", 1'b0, 'h60, 0);
    for (int i = 1; i < 4; i++) begin
      send(order[i], OP_LOAD, 'h60, 0);
      expect_quiet_mem("R2 order merged");
    end
    mem_return('h60, 32'hBEEF);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      expect_rsp("R3 arrival order", order[i], 'h60, 32'hBEEF);
    end
    @(negedge clk);
    send(0, OP_LOAD, 'h60, 0);
    expect_mem("R6 four-way session closed", 1'b0, 'h60, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs held in reset", {62'd0, rsp_valid, mem_req_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_merge();
    t_reduce();
    t_single();
    t_full();
    t_kind();
    t_order();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule